// File: doc/BRIEF.md
# Manchester Line Receiver with Drift Tracking

This block takes a Manchester-coded serial line, sampled by a clock running at sixteen times the bit rate, and turns it back into bytes. A frame opens with a one-bit start delimiter whose mid-bit transition is high-to-low. That edge is the timing reference for the data bits. Each of the eight data bits that follow is decoded from the direction of its own mid-bit transition. The bits are collected least significant first, and the finished byte is presented with a one-clock valid strobe.

The transmitter's clock may run slightly fast or slow. To follow it, the receiver watches where each mid-bit transition falls relative to the point where it expected one. A small offset is treated as jitter and leaves the timing alone. A larger offset shortens or lengthens the current bit period by exactly one sample clock. This correction is allowed only when it is enabled and the 16x sampling mode is selected. If no transition appears inside the tolerance window, the receiver raises a one-clock error and goes back to waiting for the next delimiter.

Top module: `mchr_rx`

## Requirements
- R1: Reset (synchronous, active high) clears `data_out` to 0 and holds `data_valid` and `mid_err` low. A frame that was partly received before the reset produces no strobe and no error afterwards.
- R2: While hunting, a high-to-low line transition starts a frame. Each following mid-bit transition gives one data bit: high-to-low is 1 and low-to-high is 0 when `pol_inv` is 0. After eight bits the byte is placed on `data_out` with bit 0 taken from the first bit received. The latency is counted from the clock edge that first samples the delimiter edge on `rx_in`, which is edge 0. `data_valid` is high right after edge 21 plus the sum of the periods of data bits 0 to 6, which is edge 133 with nominal 16-clock bits.
- R3: With `pol_inv` at 1 the mapping is inverted: low-to-high is 1 and high-to-low is 0. The delimiter is always a high-to-low edge.
- R4: A mid-bit transition within one sample clock of the expected point, early or late, leaves the bit period at 16.
- R5: With compensation active, a transition 2 to 4 sample clocks before the expected point makes that bit period 15.
- R6: With compensation active, a transition 2 or 3 sample clocks after the expected point makes that bit period 17.
- R7: Transitions more than 4 clocks early or more than 3 clocks late are ignored. If none lands inside the window, `mid_err` pulses right after edge 21 plus the sum of the preceding data-bit periods, and the receiver resumes hunting.
- R8: With `drift_en` at 0 every bit period is 16 sample clocks. A stream with 17-clock bits then fails at data bit 3 (error at edge 69).
- R9: With `os16_sel` at 0 the compensation is bypassed even when `drift_en` is 1, giving the same behaviour as R8.
- R10: After an error or a completed byte, the next delimiter begins a new frame that decodes normally.
- R11: While `sample_en` is low the receiver's timing and state do not advance. A delimiter edge presented and removed while it is low produces no error and no strobe.
- R12: `data_valid` and `mid_err` are single-clock pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, 16x bit rate |
| rst | input | 1 | Synchronous active-high reset |
| sample_en | input | 1 | Qualifies each clock as one line sample |
| rx_in | input | 1 | Raw serial line |
| drift_en | input | 1 | Enables period correction |
| os16_sel | input | 1 | 1 selects 16x sampling; 0 bypasses compensation |
| pol_inv | input | 1 | Inverts the bit-value mapping of mid-bit edges |
| data_out | output | 8 | Last decoded byte |
| data_valid | output | 1 | One-clock strobe for a new byte |
| mid_err | output | 1 | One-clock pulse for a missing mid-bit transition |

## Verification
A wrong period decision does not change the byte. It moves the strobe by one clock for every bit that was corrected, so the bench checks the exact strobe edge for every stream. A stuck or missing correction shows within a few bits as an error pulse on a drifting stream. Window limits that are off by one show as an error or a timing shift at the very first data bit. A mis-tracked bit index or shift register appears as a wrong byte at the first strobe.

// File: rtl/mchr_pkg.sv
package mchr_pkg;
  typedef enum logic [1:0] {
    ADJ_NONE  = 2'd0,
    ADJ_SHORT = 2'd1,
    ADJ_LONG  = 2'd2
  } adj_e;

  typedef enum logic {
    ST_HUNT = 1'b0,
    ST_DATA = 1'b1
  } rx_st_e;
endpackage

// File: rtl/mchr_edge_sync.sv
module mchr_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sample_en,
  input  logic rx_in,
  output logic edge_any,
  output logic edge_fall
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   line_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], rx_in};
      if (sample_en) prev_q <= line_now;
    end
  end

  assign line_now  = sync_q[SYNC_STAGES-1];
  assign edge_any  = sample_en && (line_now != prev_q);
  assign edge_fall = edge_any && !line_now;
endmodule

// File: rtl/mchr_window.sv
module mchr_window
  import mchr_pkg::*;
#(
  parameter int OVS       = 16,
  parameter int EARLY_MAX = 4,
  parameter int EARLY_MIN = 2,
  parameter int LATE_MIN  = 2,
  parameter int LATE_MAX  = 3,
  parameter int CW        = 5
) (
  input  logic [CW-1:0] cnt,
  input  logic          comp_on,
  output logic          in_win,
  output logic          win_end,
  output adj_e          adj
);
  localparam logic [CW-1:0] W_LO  = CW'(OVS - EARLY_MAX);
  localparam logic [CW-1:0] E_HI  = CW'(OVS - EARLY_MIN);
  localparam logic [CW-1:0] L_LO  = CW'(OVS + LATE_MIN);
  localparam logic [CW-1:0] W_HI  = CW'(OVS + LATE_MAX);

  always_comb begin
    in_win  = (cnt >= W_LO) && (cnt <= W_HI);
    win_end = (cnt == W_HI);
    adj     = ADJ_NONE;
    if (comp_on) begin
      if (cnt >= W_LO && cnt <= E_HI)      adj = ADJ_SHORT;
      else if (cnt >= L_LO && cnt <= W_HI) adj = ADJ_LONG;
    end
  end
endmodule

// File: rtl/mchr_deser.sv
module mchr_deser #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          frame_start,
  input  logic          bit_strobe,
  input  logic          bit_val,
  output logic          last_bit,
  output logic [DW-1:0] data_out,
  output logic          data_valid
);
  localparam int IW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [IW-1:0] LAST = IW'(DW - 1);

  logic [IW-1:0] idx_q;
  logic [DW-1:0] sh_q;

  assign last_bit = (idx_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q      <= '0;
      sh_q       <= '0;
      data_out   <= '0;
      data_valid <= 1'b0;
    end else begin
      data_valid <= 1'b0;
      if (frame_start) begin
        idx_q <= '0;
      end else if (bit_strobe) begin
        sh_q <= {bit_val, sh_q[DW-1:1]};
        if (last_bit) begin
          data_out   <= {bit_val, sh_q[DW-1:1]};
          data_valid <= 1'b1;
          idx_q      <= '0;
        end else begin
          idx_q <= idx_q + IW'(1);
        end
      end
    end
  end

  // R2: a byte strobe only follows the strobe of the final bit
  a_r2_valid_after_last: assert property (@(posedge clk) disable iff (rst)
    data_valid |-> ($past(bit_strobe) && $past(last_bit)));

  // R12: byte strobe lasts one clock
  a_r12_valid_single: assert property (@(posedge clk) disable iff (rst)
    data_valid |=> !data_valid);
endmodule

// File: rtl/mchr_rx.sv
module mchr_rx
  import mchr_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int EARLY_MAX   = 4,
  parameter int EARLY_MIN   = 2,
  parameter int LATE_MIN    = 2,
  parameter int LATE_MAX    = 3,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sample_en,
  input  logic          rx_in,
  input  logic          drift_en,
  input  logic          os16_sel,
  input  logic          pol_inv,
  output logic [DW-1:0] data_out,
  output logic          data_valid,
  output logic          mid_err
);
  localparam int WIN_HI = OVS + LATE_MAX;
  localparam int CW     = $clog2(WIN_HI + 2);
  localparam logic [CW-1:0] WIN_HI_C     = CW'(WIN_HI);
  localparam logic [CW-1:0] RELOAD_NOM   = CW'(WIN_HI + 1 - OVS);
  localparam logic [CW-1:0] RELOAD_SHORT = CW'(WIN_HI + 1 - (OVS - 1));
  localparam logic [CW-1:0] RELOAD_LONG  = CW'(WIN_HI + 1 - (OVS + 1));

  rx_st_e        st_q;
  logic [CW-1:0] cnt_q;
  logic          seen_q, sval_q;
  adj_e          sadj_q;

  logic    edge_any, edge_fall;
  logic    in_win, win_end, comp_on;
  adj_e    adj_now, adj_use;
  logic    hit_now, got, bit_now, bit_strobe, frame_start, last_bit;
  logic [CW-1:0] reload;

  mchr_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .sample_en(sample_en), .rx_in(rx_in),
    .edge_any(edge_any), .edge_fall(edge_fall)
  );

  assign comp_on = drift_en && os16_sel;

  mchr_window #(
    .OVS(OVS), .EARLY_MAX(EARLY_MAX), .EARLY_MIN(EARLY_MIN),
    .LATE_MIN(LATE_MIN), .LATE_MAX(LATE_MAX), .CW(CW)
  ) u_win (
    .cnt(cnt_q), .comp_on(comp_on),
    .in_win(in_win), .win_end(win_end), .adj(adj_now)
  );

  always_comb begin
    hit_now     = edge_any && in_win;
    got         = seen_q || hit_now;
    bit_now     = seen_q ? sval_q : (edge_fall ^ pol_inv);
    adj_use     = seen_q ? sadj_q : adj_now;
    bit_strobe  = sample_en && (st_q == ST_DATA) && win_end && got;
    frame_start = (st_q == ST_HUNT) && edge_fall;
    unique case (adj_use)
      ADJ_SHORT: reload = RELOAD_SHORT;
      ADJ_LONG:  reload = RELOAD_LONG;
      default:   reload = RELOAD_NOM;
    endcase
  end

  mchr_deser #(.DW(DW)) u_deser (
    .clk(clk), .rst(rst), .frame_start(frame_start),
    .bit_strobe(bit_strobe), .bit_val(bit_now), .last_bit(last_bit),
    .data_out(data_out), .data_valid(data_valid)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_HUNT;
      cnt_q   <= '0;
      seen_q  <= 1'b0;
      sval_q  <= 1'b0;
      sadj_q  <= ADJ_NONE;
      mid_err <= 1'b0;
    end else begin
      mid_err <= 1'b0;
      if (sample_en) begin
        unique case (st_q)
          ST_HUNT: begin
            if (edge_fall) begin
              st_q   <= ST_DATA;
              cnt_q  <= CW'(1);
              seen_q <= 1'b0;
            end
          end
          ST_DATA: begin
            if (win_end) begin
              seen_q <= 1'b0;
              if (got) begin
                cnt_q <= reload;
                if (last_bit) st_q <= ST_HUNT;
              end else begin
                mid_err <= 1'b1;
                st_q    <= ST_HUNT;
              end
            end else begin
              cnt_q <= cnt_q + CW'(1);
              if (hit_now && !seen_q) begin
                seen_q <= 1'b1;
                sval_q <= edge_fall ^ pol_inv;
                sadj_q <= adj_now;
              end
            end
          end
          default: st_q <= ST_HUNT;
        endcase
      end
    end
  end

  // R11: no timing or state advance without a sample enable
  a_r11_frozen: assert property (@(posedge clk) disable iff (rst)
    !sample_en |=> ($stable(cnt_q) && $stable(st_q)));

  // R8: without compensation every accepted bit restarts on the nominal count
  a_r8_fixed_period: assert property (@(posedge clk) disable iff (rst)
    (bit_strobe && !comp_on) |=> (cnt_q == RELOAD_NOM));

  // R7: error only at the close of a data-bit window
  a_r7_err_at_end: assert property (@(posedge clk) disable iff (rst)
    mid_err |-> ($past(st_q) == ST_DATA && $past(cnt_q) == WIN_HI_C));

  // R12: error lasts one clock and never coincides with a byte strobe
  a_r12_err_single: assert property (@(posedge clk) disable iff (rst)
    mid_err |=> !mid_err);
  a_r12_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(mid_err && data_valid));
endmodule

// File: tb/mchr_rx_bench.sv
module mchr_rx_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sample_en = 1'b1;
  logic rx_in = 1'b1;
  logic drift_en = 1'b0;
  logic os16_sel = 1'b1;
  logic pol_inv = 1'b0;
  logic [7:0] data_out;
  logic data_valid, mid_err;

  always #5 clk = ~clk;

  mchr_rx u_mchr_rx (
    .clk(clk), .rst(rst), .sample_en(sample_en), .rx_in(rx_in),
    .drift_en(drift_en), .os16_sel(os16_sel), .pol_inv(pol_inv),
    .data_out(data_out), .data_valid(data_valid), .mid_err(mid_err)
  );

  typedef struct packed {
    logic [7:0]        data;
    logic              txp;
    logic              rxp;
    logic              comp;
    logic              os16;
    logic [4:0]        len;
    logic signed [3:0] jit;
    logic              want_byte;
    logic [7:0]        expb;
    logic [7:0]        lat;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{8'hA5, 1'b0, 1'b0, 1'b0, 1'b1, 5'd16,  4'sd0, 1'b1, 8'hA5, 8'd133},
    '{8'h3C, 1'b0, 1'b0, 1'b1, 1'b1, 5'd16,  4'sd0, 1'b1, 8'h3C, 8'd133},
    '{8'hA5, 1'b0, 1'b0, 1'b1, 1'b1, 5'd17,  4'sd0, 1'b1, 8'hA5, 8'd139},
    '{8'hA5, 1'b0, 1'b0, 1'b0, 1'b1, 5'd17,  4'sd0, 1'b0, 8'h00, 8'd69},
    '{8'hA5, 1'b0, 1'b0, 1'b1, 1'b0, 5'd17,  4'sd0, 1'b0, 8'h00, 8'd69},
    '{8'h96, 1'b0, 1'b0, 1'b1, 1'b1, 5'd15,  4'sd0, 1'b1, 8'h96, 8'd127},
    '{8'hC3, 1'b0, 1'b0, 1'b1, 1'b1, 5'd16, -4'sd3, 1'b1, 8'hC3, 8'd131},
    '{8'hC3, 1'b0, 1'b0, 1'b0, 1'b1, 5'd16, -4'sd3, 1'b1, 8'hC3, 8'd133},
    '{8'h0F, 1'b0, 1'b0, 1'b1, 1'b1, 5'd16,  4'sd3, 1'b1, 8'h0F, 8'd135},
    '{8'h0F, 1'b0, 1'b0, 1'b1, 1'b1, 5'd16,  4'sd1, 1'b1, 8'h0F, 8'd133},
    '{8'h0F, 1'b0, 1'b0, 1'b1, 1'b1, 5'd16, -4'sd1, 1'b1, 8'h0F, 8'd133},
    '{8'h81, 1'b0, 1'b0, 1'b1, 1'b1, 5'd16, -4'sd4, 1'b1, 8'h81, 8'd130},
    '{8'h81, 1'b0, 1'b0, 1'b1, 1'b1, 5'd16,  4'sd2, 1'b1, 8'h81, 8'd134},
    '{8'hA5, 1'b0, 1'b0, 1'b1, 1'b1, 5'd16, -4'sd5, 1'b0, 8'h00, 8'd21},
    '{8'hA5, 1'b0, 1'b0, 1'b1, 1'b1, 5'd16,  4'sd4, 1'b0, 8'h00, 8'd21},
    '{8'h6B, 1'b1, 1'b1, 1'b1, 1'b1, 5'd16,  4'sd0, 1'b1, 8'h6B, 8'd133},
    '{8'h6B, 1'b0, 1'b1, 1'b1, 1'b1, 5'd16,  4'sd0, 1'b1, 8'h94, 8'd133}
  };

  function automatic string tag_of(input int i);
    case (i)
      0, 1:       return "R2";
      2, 8, 12:   return "R6";
      3, 7:       return "R8";
      4:          return "R9";
      5, 6, 11:   return "R5";
      9, 10:      return "R4";
      13, 14:     return "R7";
      default:    return "R3";
    endcase
  endfunction

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_fail = 0;
  bit got = 1'b0;
  bit evt_valid = 1'b0;
  logic [7:0] evt_byte = 8'h00;
  int evt_cyc = 0;
  int valid_pulses = 0;
  int err_pulses = 0;

  always @(negedge clk) begin
    if (data_valid) valid_pulses++;
    if (mid_err) err_pulses++;
    if (!got && (data_valid || mid_err)) begin
      got = 1'b1;
      evt_valid = data_valid;
      evt_byte = data_out;
      evt_cyc = cyc;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic hold(input logic lvl, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_in = lvl;
    end
  endtask

  task automatic arm();
    got = 1'b0;
    valid_pulses = 0;
    err_pulses = 0;
  endtask

  task automatic send_frame(input logic [7:0] d, input logic txp, input int len,
                            input int jit, output int sfd_n);
    int h;
    h = len / 2;
    hold(1'b1, 20);
    arm();
    hold(1'b1, h);
    @(negedge clk);
    rx_in = 1'b0;
    sfd_n = cyc + 1;
    hold(1'b0, len - h - 1);
    for (int k = 0; k < 8; k++) begin
      logic f;
      f = d[k] ^ txp;
      hold(f, h + jit);
      hold(!f, len - h - jit);
    end
    hold(1'b1, 40);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    int sfd_n;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(data_out == 8'h00, "R1", data_out, 0);
    check(data_valid == 1'b0, "R1", data_valid, 0);
    check(mid_err == 1'b0, "R1", mid_err, 0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      drift_en = VEC[i].comp;
      os16_sel = VEC[i].os16;
      pol_inv  = VEC[i].rxp;
      send_frame(VEC[i].data, VEC[i].txp, int'(VEC[i].len), int'(VEC[i].jit), sfd_n);
      check(got, tag_of(i), got, 1);
      check(evt_valid == VEC[i].want_byte, tag_of(i), evt_valid, VEC[i].want_byte);
      check((evt_cyc - sfd_n) == int'(VEC[i].lat), tag_of(i), evt_cyc - sfd_n, VEC[i].lat);
      if (VEC[i].want_byte) begin
        check(evt_byte == VEC[i].expb, tag_of(i), evt_byte, VEC[i].expb);
        check(valid_pulses == 1, "R12", valid_pulses, 1);
      end
    end

    // R7 / R12: delimiter with no following mid-bit edge
    drift_en = 1'b1; os16_sel = 1'b1; pol_inv = 1'b0;
    hold(1'b1, 20);
    arm();
    hold(1'b1, 8);
    @(negedge clk);
    rx_in = 1'b0;
    sfd_n = cyc + 1;
    hold(1'b0, 40);
    check(got && !evt_valid, "R7", evt_valid, 0);
    check((evt_cyc - sfd_n) == 21, "R7", evt_cyc - sfd_n, 21);
    check(err_pulses == 1, "R12", err_pulses, 1);
    check(valid_pulses == 0, "R12", valid_pulses, 0);

    // R10: a clean frame right after an error
    send_frame(8'h5A, 1'b0, 16, 0, sfd_n);
    check(got && evt_valid, "R10", evt_valid, 1);
    check(evt_byte == 8'h5A, "R10", evt_byte, 8'h5A);
    check((evt_cyc - sfd_n) == 133, "R10", evt_cyc - sfd_n, 133);

    // R11: delimiter edge applied and removed with sample_en low
    hold(1'b1, 20);
    arm();
    sample_en = 1'b0;
    hold(1'b0, 80);
    hold(1'b1, 10);
    sample_en = 1'b1;
    hold(1'b1, 40);
    check(!got, "R11", got, 0);

    // R1: reset in the middle of a frame
    hold(1'b1, 20);
    hold(1'b0, 8);
    hold(1'b1, 8);
    hold(1'b0, 8);
    @(negedge clk);
    rst = 1'b1;
    rx_in = 1'b1;
    hold(1'b1, 3);
    check(data_out == 8'h00, "R1", data_out, 0);
    check(data_valid == 1'b0 && mid_err == 1'b0, "R1", data_valid | mid_err, 0);
    rst = 1'b0;
    arm();
    hold(1'b1, 60);
    check(!got, "R1", got, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule